// File: doc/BRIEF.md
# Bit-Vector NFA Stream Matcher

The block scans a byte stream against a nondeterministic finite automaton held in loadable tables. It does not convert the automaton into a deterministic machine first. It keeps one flag per automaton state, so any combination of states can be live at the same time. Each automaton state owns a lookup table indexed by the incoming byte. The tables of all live states are read in the same cycle, and their outputs are merged by OR into the next set of live states. The block raises a sticky match flag on the first character after which any accepting state is live. This is what lets it report a hit partway through the stream, without waiting for the end of the input.

Software loads three things through a narrow write port: the per-state tables, the set of states entered at the start, and the set of accepting states. A write is taken only in a cycle with no character offered. Epsilon moves must already be folded into the table contents. A mode input injects the start set after every character, so a match can begin at any stream position. Once a match is flagged, the block holds its state and refuses input until a restart pulse reloads the start set.

The number of states `N_STATES` is a parameter, valid up to 64. The state vector and each table word are `N_STATES` bits wide, and each table has 2^`SYM_W` words.

Top module: `nfa_scan_top`

## Requirements
- R1: After reset the live-state vector equals the parameter `START_RST` (default: only state 0), the start set equals `START_RST`, the accepting set and every table word are zero, `match_o` is 0 and `in_ready_o` is 1.
- R2: When a character is accepted (`in_valid_i` and `in_ready_o` both high), the next live-state vector is the OR of `table[s][in_char_i]` over every state s that is live, and it appears on `state_o` one cycle later.
- R3: A state that is not live contributes nothing to the next vector, whatever its table holds for the current character.
- R4: While `float_start_i` is 1 on an accepted character, the start set is ORed into the next vector as well.
- R5: `match_o` rises in the cycle after an accepted character whose next vector shares a set bit with the accepting set, and it rises only after an accepted character.
- R6: While `match_o` is 1, `in_ready_o` is 0. Offered characters are not consumed, and `state_o` and `match_o` hold until a restart.
- R7: A high `restart_i` loads the start set into the live vector and clears `match_o` on the next edge. During that cycle `in_ready_o` is 0, so a character offered in the same cycle is not consumed.
- R8: A configuration write with `cfg_we_i`=1 takes effect only in a cycle where `in_valid_i`=0. `cfg_sel_i` selects the target: 0 writes `cfg_data_i` to table word `[cfg_state_i][cfg_addr_i]`, 1 writes the start set, 2 writes the accepting set, and 3 writes nothing. Writes made while a match is held are allowed.
- R9: In a cycle with no accepted character and no restart, `state_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Reload start set, clear match |
| float_start_i | input | 1 | 1: inject start set after every character |
| in_valid_i | input | 1 | Character offered |
| in_char_i | input | SYM_W | Character value |
| in_ready_o | output | 1 | Character can be accepted |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 table, 1 start set, 2 accepting set |
| cfg_state_i | input | IDX_W | Table owner state index |
| cfg_addr_i | input | SYM_W | Table word address (character) |
| cfg_data_i | input | N_STATES | Write data |
| match_o | output | 1 | Sticky match flag |
| state_o | output | N_STATES | Live-state vector |

## Verification
The bench builds the block with 8 states and 8-bit characters. At that size every table word can be left at its reset value or set directly, and the whole state vector can be compared bit for bit on every clock against a behavioural model. That makes reachable the cases that depend on several states being live together: two paths that merge, a live state and a dead state that both hold entries for the same byte, and the start set being re-injected on top of states that are already live. The 8-bit character width exercises the full byte address range of each table.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    CFG_TABLE  = 2'd0,
    CFG_START  = 2'd1,
    CFG_ACCEPT = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nfa_step_unit.sv
// One transition table per automaton state; read is gated by the state's live bit.
module nfa_step_unit #(
  parameter int N_STATES = 8,
  parameter int SYM_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SYM_W-1:0]    wr_addr_i,
  input  logic [N_STATES-1:0] wr_data_i,
  input  logic [SYM_W-1:0]    rd_addr_i,
  input  logic                act_i,
  output logic [N_STATES-1:0] row_o
);
  localparam int DEPTH = 1 << SYM_W;

  logic [N_STATES-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign row_o = act_i ? mem_q[rd_addr_i] : '0;

  assert_table_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/nfa_merge.sv
// OR-reduce of gated rows, plus optional start-set injection.
module nfa_merge #(
  parameter int N_STATES = 8
) (
  input  logic [N_STATES-1:0][N_STATES-1:0] rows_i,
  input  logic [N_STATES-1:0]               start_i,
  input  logic                              float_i,
  output logic [N_STATES-1:0]               next_o
);
  always_comb begin
    next_o = float_i ? start_i : '0;
    for (int s = 0; s < N_STATES; s++) next_o = next_o | rows_i[s];
  end
endmodule

// File: rtl/nfa_run_ctrl.sv
// Live-state register, start/accept sets and sticky match.
module nfa_run_ctrl
  import nfa_pkg::*;
#(
  parameter int                  N_STATES  = 8,
  parameter logic [N_STATES-1:0] START_RST = N_STATES'(1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                step_i,
  input  logic [N_STATES-1:0] next_i,
  input  logic                cfg_wr_i,
  input  cfg_sel_e            cfg_sel_i,
  input  logic [N_STATES-1:0] cfg_data_i,
  output logic [N_STATES-1:0] state_o,
  output logic [N_STATES-1:0] start_o,
  output logic                match_o
);
  logic [N_STATES-1:0] state_q, start_q, accept_q;
  logic                match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= START_RST;
      start_q  <= START_RST;
      accept_q <= '0;
      match_q  <= 1'b0;
    end else begin
      if (cfg_wr_i && cfg_sel_i == CFG_START)  start_q  <= cfg_data_i;
      if (cfg_wr_i && cfg_sel_i == CFG_ACCEPT) accept_q <= cfg_data_i;
      if (restart_i) begin
        state_q <= start_q;
        match_q <= 1'b0;
      end else if (step_i) begin
        state_q <= next_i;
        match_q <= |(next_i & accept_q);
      end
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign match_o = match_q;

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(state_q));
  assert_restart_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == $past(start_q)) && !match_q);
  assert_match_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q && !restart_i) |=> match_q && $stable(state_q));
  assert_match_after_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_q) |-> $past(step_i));
endmodule

// File: rtl/nfa_scan_top.sv
module nfa_scan_top
  import nfa_pkg::*;
#(
  parameter int                  N_STATES  = 8,
  parameter int                  SYM_W     = 8,
  parameter logic [N_STATES-1:0] START_RST = N_STATES'(1),
  localparam int                 IDX_W     = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                float_start_i,
  input  logic                in_valid_i,
  input  logic [SYM_W-1:0]    in_char_i,
  output logic                in_ready_o,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [IDX_W-1:0]    cfg_state_i,
  input  logic [SYM_W-1:0]    cfg_addr_i,
  input  logic [N_STATES-1:0] cfg_data_i,
  output logic                match_o,
  output logic [N_STATES-1:0] state_o
);
  logic [N_STATES-1:0][N_STATES-1:0] rows;
  logic [N_STATES-1:0]               next_vec, state_vec, start_vec;
  logic                              match_q, step, cfg_ok;
  cfg_sel_e                          sel;

  assign sel        = cfg_sel_e'(cfg_sel_i);
  assign in_ready_o = !match_q && !restart_i;
  assign step       = in_valid_i && in_ready_o;
  assign cfg_ok     = cfg_we_i && !in_valid_i;  // writes only while no character is offered

  for (genvar s = 0; s < N_STATES; s++) begin : g_unit
    nfa_step_unit #(
      .N_STATES(N_STATES),
      .SYM_W   (SYM_W)
    ) u_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (cfg_ok && sel == CFG_TABLE && cfg_state_i == IDX_W'(s)),
      .wr_addr_i(cfg_addr_i),
      .wr_data_i(cfg_data_i),
      .rd_addr_i(in_char_i),
      .act_i    (state_vec[s]),
      .row_o    (rows[s])
    );
  end

  nfa_merge #(.N_STATES(N_STATES)) u_merge (
    .rows_i (rows),
    .start_i(start_vec),
    .float_i(float_start_i),
    .next_o (next_vec)
  );

  nfa_run_ctrl #(
    .N_STATES (N_STATES),
    .START_RST(START_RST)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .step_i    (step),
    .next_i    (next_vec),
    .cfg_wr_i  (cfg_ok),
    .cfg_sel_i (sel),
    .cfg_data_i(cfg_data_i),
    .state_o   (state_vec),
    .start_o   (start_vec),
    .match_o   (match_q)
  );

  assign match_o = match_q;
  assign state_o = state_vec;

  assert_float_inject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && float_start_i) |=> ((state_vec & $past(start_vec)) == $past(start_vec)));
  assert_busy_write_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && in_valid_i) |=> $stable(start_vec));
  assert_ready_low_matched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(match_q && !restart_i) |-> !in_ready_o);
endmodule

// File: tb/tb_nfa_scan_top.sv
`timescale 1ns/1ps
module tb_nfa_scan_top;
  localparam int N  = 8;
  localparam int SW = 8;
  localparam int IW = 3;

  logic          clk_i = 0, rst_ni = 0;
  logic          restart_i = 0, float_start_i = 0, in_valid_i = 0, cfg_we_i = 0;
  logic [SW-1:0] in_char_i = '0, cfg_addr_i = '0;
  logic [1:0]    cfg_sel_i = 2'd3;
  logic [IW-1:0] cfg_state_i = '0;
  logic [N-1:0]  cfg_data_i = '0;
  logic          in_ready_o, match_o;
  logic [N-1:0]  state_o;

  always #2 clk_i = ~clk_i;

  nfa_scan_top dut (
    .clk_i, .rst_ni, .restart_i, .float_start_i, .in_valid_i, .in_char_i,
    .in_ready_o, .cfg_we_i, .cfg_sel_i, .cfg_state_i, .cfg_addr_i,
    .cfg_data_i, .match_o, .state_o
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_state = 8'h01, m_start = 8'h01, m_acc = '0;
  bit           m_match = 0;
  logic [N-1:0] m_tbl [N][256];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, check ready, advance model, compare after edge.
  task automatic cyc(string req, bit rs, bit fl, bit v, logic [7:0] ch,
                     bit we, logic [1:0] sel, logic [IW-1:0] si, logic [7:0] ad, logic [N-1:0] d);
    logic [N-1:0] nx;
    restart_i = rs; float_start_i = fl; in_valid_i = v; in_char_i = ch;
    cfg_we_i = we; cfg_sel_i = sel; cfg_state_i = si; cfg_addr_i = ad; cfg_data_i = d;
    #1;
    chk(req, "in_ready", 64'(in_ready_o), 64'(!m_match && !rs));
    if (rs) begin
      m_state = m_start; m_match = 0;
    end else if (v && !m_match) begin
      nx = fl ? m_start : '0;
      for (int i = 0; i < N; i++) if (m_state[i]) nx = nx | m_tbl[i][ch];
      m_state = nx;
      if ((nx & m_acc) != 0) m_match = 1;
    end
    if (we && !v) begin
      case (sel)
        2'd0: m_tbl[si][ad] = d;
        2'd1: m_start = d;
        2'd2: m_acc = d;
        default: ;
      endcase
    end
    @(posedge clk_i); @(negedge clk_i);
    chk(req, "state", 64'(state_o), 64'(m_state));
    chk(req, "match", 64'(match_o), 64'(m_match));
    restart_i = 0; in_valid_i = 0; cfg_we_i = 0;
  endtask

  task automatic feed(string req, logic [7:0] ch, bit fl);
    cyc(req, 0, fl, 1, ch, 0, 2'd3, '0, '0, '0);
  endtask
  task automatic idle(string req);
    cyc(req, 0, 0, 0, '0, 0, 2'd3, '0, '0, '0);
  endtask
  task automatic restart(string req);
    cyc(req, 1, 0, 0, '0, 0, 2'd3, '0, '0, '0);
  endtask
  task automatic wr(string req, logic [1:0] sel, logic [IW-1:0] si, logic [7:0] ad, logic [N-1:0] d);
    cyc(req, 0, 0, 0, '0, 1, sel, si, ad, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) for (int a = 0; a < 256; a++) m_tbl[i][a] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1", "reset state", 64'(state_o), 64'h01);
    chk("R1", "reset match", 64'(match_o), 64'h0);
    chk("R1", "reset ready", 64'(in_ready_o), 64'h1);
    @(negedge clk_i);
    feed("R1", 8'h61, 0);              // zero tables: vector dies, no match
    idle("R9");
    restart("R7");
    // program: 0-a->1, 1-b->2, 0-x->{1,3}, 3-b->4, 5-b->7, accept {2}
    wr("R8", 2'd1, 0, 0, 8'h01);
    wr("R8", 2'd0, 0, 8'h61, 8'h02);
    wr("R8", 2'd0, 1, 8'h62, 8'h04);
    wr("R8", 2'd0, 0, 8'h78, 8'h0A);
    wr("R8", 2'd0, 3, 8'h62, 8'h10);
    wr("R8", 2'd0, 5, 8'h62, 8'h80);
    wr("R8", 2'd3, 6, 8'h62, 8'hFF);   // sel 3 writes nothing
    wr("R8", 2'd2, 0, 0, 8'h04);
    restart("R7");
    feed("R2", 8'h61, 0);
    idle("R9");
    idle("R9");
    feed("R5", 8'h62, 0);              // match
    feed("R6", 8'h61, 0);              // refused
    feed("R6", 8'h62, 0);
    idle("R6");
    restart("R7");
    feed("R3", 8'h78, 0);              // {1,3}
    feed("R3", 8'h62, 0);              // {2,4}, state 5 dead, bit 7 stays clear
    restart("R7");
    feed("R2", 8'h63, 0);              // anchored: dies
    feed("R2", 8'h61, 0);
    feed("R2", 8'h62, 0);
    restart("R7");
    feed("R4", 8'h63, 1);
    feed("R4", 8'h61, 1);
    feed("R4", 8'h78, 1);              // {1,3} | {0} | ...
    feed("R4", 8'h62, 1);              // match
    restart("R7");
    cyc("R8", 0, 0, 1, 8'h71, 1, 2'd2, 0, 0, 8'h00); // write dropped while busy
    restart("R7");
    cyc("R8", 0, 0, 1, 8'h71, 1, 2'd0, 0, 8'h61, 8'h00);
    restart("R7");
    feed("R8", 8'h61, 0);
    feed("R8", 8'h62, 0);              // still matches: dropped writes had no effect
    wr("R8", 2'd1, 0, 0, 8'h08);       // write while matched is taken
    restart("R7");
    wr("R8", 2'd1, 0, 0, 8'h01);
    restart("R7");
    cyc("R7", 1, 0, 1, 8'h61, 0, 2'd3, 0, 0, 0); // char with restart not consumed
    feed("R7", 8'h61, 0);
    feed("R5", 8'h62, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule